// File: doc/BRIEF.md
# Six-Mode Programmable Interval Counter

This block is a single 16-bit binary down-counter channel. It has a gate input and one waveform output. A small byte-wide write port carries two kinds of write: a control word, and the count bytes. The control word picks one of six operating modes and says whether the count arrives as one byte or as two. The count then follows as a low byte only, or as a low byte and then a high byte. From these the block makes terminal-count flags, retriggerable one-shot pulses, periodic rate pulses, square waves and single-clock strobes.

Every rising edge of `clk` counts as one counting clock. The gate input is read at those edges. A rising edge of the gate is found by comparing the present sample with a registered copy of the previous one. The gate level can pause counting in some modes. A gate rising edge acts as a trigger in others.

Top module: `pit_counter`

## Requirements
- R1: A write with `wr_sel`=1 is a control word. Bits [3:1] give the mode, and codes 6 and 7 behave as modes 2 and 3. Bit 4 chooses the count format: 0 means low byte only, 1 means low byte then high byte. A write with `wr_sel`=0 carries a count byte, and a count takes effect only when its last byte has been written.
- R2: In mode 0, `wave_o` goes low at the edge that takes the control word. It stays low until N+1 clocks after the edge that completes a count of N. It then stays high until the next count byte or control word is written.
- R3: In mode 0, each clock at which `en_gate` is low skips one decrement. This delays the rising edge of `wave_o` by one clock per such clock. The gate level itself does not drive `wave_o`.
- R4: In mode 0 with two-byte counts, writing the low byte forces `wave_o` low at that edge and halts counting. After the high byte, `wave_o` rises N+1 clocks later.
- R5: In mode 1, a rising edge of `en_gate` loads the most recently completed count, and `wave_o` is then low for exactly N clocks. A new rising edge during the pulse reloads the newest count and restarts the N-clock low time.
- R6: In mode 2, `wave_o` repeats with a period of N clocks and is low for one clock of each period. With `en_gate` low, `wave_o` is high at once and counting stops. A rising edge of `en_gate` reloads the count, and `wave_o` next goes low N clocks after that edge.
- R7: In mode 3, `wave_o` is high for (N+1)/2 clocks and low for N/2 clocks, both rounded down. With `en_gate` low, `wave_o` is high at once.
- R8: In modes 2 and 3, a count written while the counter is running is first used when the current period or half-period ends.
- R9: In mode 4, completing a count write starts a strobe. `wave_o` is low for one clock, N+1 clocks after the completing edge, and does not repeat. A new count written during counting restarts the delay.
- R10: In mode 5, a rising edge of `en_gate` loads the count, and `wave_o` goes low for one clock N+1 clocks after the gate is raised. A new rising edge before the strobe restarts the delay.
- R11: A count value of 0 stands for 65536 clocks.
- R12: While reset is held and just after it is released, `wave_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock; every rising edge is one count clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| wr_sel | input | 1 | 1 selects a control word, 0 a count byte |
| wr_data | input | 8 | Write data byte |
| en_gate | input | 1 | Gate: a level enable or a rising-edge trigger, depending on the mode |
| wave_o | output | 1 | Counter output waveform |

## Verification
Each mode is swept over a run of small counts, with the expected edge positions worked out from the arithmetic for that mode. For mode 3 the sweep covers both odd and even counts, and this tells correct rounding of the two half-periods apart from a plain divide by two. The gate is tried in three ways: pulled low partway through a count, pulled low while the output is low, and raised a second time during a pulse or delay. These show whether the gate pauses counting, forces the output high, or restarts the count. Counts are rewritten in the middle of a period to check that the new value waits for the period boundary in modes 2 and 3 and is taken at once in mode 4. Finally, a count of zero in mode 0 confirms the full 65536-clock range.

// File: rtl/pit_pkg.sv
package pit_pkg;

   typedef enum logic [2:0] {
      PM_TC_INT    = 3'd0,
      PM_ONESHOT   = 3'd1,
      PM_RATE      = 3'd2,
      PM_SQUARE    = 3'd3,
      PM_SW_STROBE = 3'd4,
      PM_HW_STROBE = 3'd5
   } pit_mode_e;

   // codes 6 and 7 fold onto the periodic modes
   function automatic pit_mode_e pit_decode(input logic [2:0] f);
      pit_mode_e m;
      case (f)
         3'd0:    m = PM_TC_INT;
         3'd1:    m = PM_ONESHOT;
         3'd2:    m = PM_RATE;
         3'd3:    m = PM_SQUARE;
         3'd4:    m = PM_SW_STROBE;
         3'd5:    m = PM_HW_STROBE;
         3'd6:    m = PM_RATE;
         default: m = PM_SQUARE;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/pit_wr_ctrl.sv
module pit_wr_ctrl
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             wr_sel,
   input  logic [7:0]       wr_data,
   output pit_mode_e        mode,
   output logic             cw_wr,
   output pit_mode_e        cw_mode,
   output logic             byte_wr,
   output logic [CNT_W-1:0] cnt_val,
   output logic             cnt_done
);

   localparam int HI_W = CNT_W - 8;

   logic       two_byte;
   logic       hi_next;
   logic [7:0] lo_hold;

   assign cw_wr   = wr_en & wr_sel;
   assign byte_wr = wr_en & ~wr_sel;
   assign cw_mode = pit_decode(wr_data[3:1]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode     <= PM_TC_INT;
         two_byte <= 1'b0;
         hi_next  <= 1'b0;
         lo_hold  <= '0;
         cnt_val  <= '0;
         cnt_done <= 1'b0;
      end else begin
         cnt_done <= 1'b0;
         if (cw_wr) begin
            mode     <= cw_mode;
            two_byte <= wr_data[4];
            hi_next  <= 1'b0;
         end else if (byte_wr) begin
            if (!two_byte) begin
               cnt_val  <= CNT_W'(wr_data);
               cnt_done <= 1'b1;
            end else if (!hi_next) begin
               lo_hold <= wr_data;
               hi_next <= 1'b1;
            end else begin
               cnt_val  <= {wr_data[HI_W-1:0], lo_hold};
               hi_next  <= 1'b0;
               cnt_done <= 1'b1;
            end
         end
      end
   end

   // a completed count is announced for one clock only
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_done && !byte_wr |=> !cnt_done); // R1

endmodule

// File: rtl/pit_gate_edge.sv
module pit_gate_edge #(
   parameter int SYNC_STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic gate_raw,
   output logic gate_lvl,
   output logic gate_rise
);

   logic gate_q;

   generate
      if (SYNC_STAGES == 0) begin : g_direct
         assign gate_lvl = gate_raw;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sh;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= '0;
            end else begin
               sh[0] <= gate_raw;
               for (int i = 1; i < SYNC_STAGES; i++) sh[i] <= sh[i-1];
            end
         end
         assign gate_lvl = sh[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) gate_q <= 1'b0;
      else        gate_q <= gate_lvl;
   end

   assign gate_rise = gate_lvl & ~gate_q;

endmodule

// File: rtl/pit_core.sv
module pit_core
   import pit_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  pit_mode_e        mode,
   input  logic             cw_wr,
   input  pit_mode_e        cw_mode,
   input  logic             byte_wr,
   input  logic [CNT_W-1:0] cnt_val,
   input  logic             cnt_done,
   input  logic             gate_lvl,
   input  logic             gate_rise,
   output logic             out_q
);

   localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);
   localparam logic [CNT_W-1:0] TWO       = CNT_W'(2);
   localparam logic [CNT_W-1:0] HALF_FULL = {1'b1, {(CNT_W-1){1'b0}}};

   logic [CNT_W-1:0] cnt;
   logic             armed;
   logic             running;
   logic             have_cnt;
   logic             avail;
   logic [CNT_W-1:0] half_hi;
   logic [CNT_W-1:0] half_lo;

   assign avail = have_cnt | cnt_done;

   // square-wave phase lengths; a zero count means the full range
   always_comb begin
      if (cnt_val == '0) begin
         half_hi = HALF_FULL;
         half_lo = HALF_FULL;
      end else begin
         half_hi = (cnt_val >> 1) + CNT_W'(cnt_val[0]);
         half_lo = cnt_val >> 1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         out_q    <= 1'b1;
         armed    <= 1'b0;
         running  <= 1'b0;
         have_cnt <= 1'b0;
      end else if (cw_wr) begin
         out_q    <= (cw_mode != PM_TC_INT);
         armed    <= 1'b0;
         running  <= 1'b0;
         have_cnt <= 1'b0;
      end else begin
         if (cnt_done) have_cnt <= 1'b1;
         case (mode)
            PM_TC_INT: begin
               if (byte_wr) begin
                  out_q <= 1'b0;
                  armed <= 1'b0;
               end else if (cnt_done) begin
                  cnt   <= cnt_val;
                  armed <= 1'b1;
               end else if (armed && gate_lvl) begin
                  cnt <= cnt - ONE;
                  if (cnt == ONE) begin
                     out_q <= 1'b1;
                     armed <= 1'b0;
                  end
               end
            end
            PM_ONESHOT: begin
               if (gate_rise && avail) begin
                  cnt   <= cnt_val;
                  out_q <= 1'b0;
                  armed <= 1'b1;
               end else if (armed) begin
                  cnt <= cnt - ONE;
                  if (cnt == ONE) begin
                     out_q <= 1'b1;
                     armed <= 1'b0;
                  end
               end
            end
            PM_RATE: begin
               out_q <= 1'b1;
               if ((gate_rise && avail) || (cnt_done && !running)) begin
                  cnt     <= cnt_val;
                  running <= 1'b1;
               end else if (running && gate_lvl) begin
                  if (cnt == ONE) begin
                     cnt <= cnt_val;
                  end else begin
                     cnt <= cnt - ONE;
                     if (cnt == TWO) out_q <= 1'b0;
                  end
               end
            end
            PM_SQUARE: begin
               if ((gate_rise && avail) || (cnt_done && !running)) begin
                  cnt     <= half_hi;
                  out_q   <= 1'b1;
                  running <= 1'b1;
               end else if (!gate_lvl) begin
                  out_q <= 1'b1;
               end else if (running) begin
                  if (cnt == ONE) begin
                     out_q <= ~out_q;
                     cnt   <= out_q ? half_lo : half_hi;
                  end else begin
                     cnt <= cnt - ONE;
                  end
               end
            end
            PM_SW_STROBE: begin
               out_q <= 1'b1;
               if (cnt_done) begin
                  cnt   <= cnt_val;
                  armed <= 1'b1;
               end else if (armed && gate_lvl) begin
                  cnt <= cnt - ONE;
                  if (cnt == ONE) begin
                     out_q <= 1'b0;
                     armed <= 1'b0;
                  end
               end
            end
            PM_HW_STROBE: begin
               out_q <= 1'b1;
               if (gate_rise && avail) begin
                  cnt   <= cnt_val;
                  armed <= 1'b1;
               end else if (armed) begin
                  cnt <= cnt - ONE;
                  if (cnt == ONE) begin
                     out_q <= 1'b0;
                     armed <= 1'b0;
                  end
               end
            end
            default: out_q <= 1'b1;
         endcase
      end
   end

   AST_M0_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      mode == PM_TC_INT && out_q && !cw_wr && !byte_wr |=> out_q); // R2
   AST_M1_TRIG_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode == PM_ONESHOT && gate_rise && have_cnt && !cw_wr |=> !out_q); // R5
   AST_M2_ONE_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      mode == PM_RATE && !out_q && !cw_wr |=> out_q); // R6
   AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == PM_SW_STROBE || mode == PM_HW_STROBE) && !out_q && !cw_wr |=> out_q); // R9

endmodule

// File: rtl/pit_counter.sv
module pit_counter
   import pit_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic       wr_sel,
   input  logic [7:0] wr_data,
   input  logic       en_gate,
   output logic       wave_o
);

   generate
      if (CNT_W < 9 || CNT_W > 16) begin : g_bad_width
         $error("pit_counter: CNT_W must lie in 9..16");
      end
      if (SYNC_STAGES == 1 || SYNC_STAGES < 0) begin : g_bad_sync
         $error("pit_counter: SYNC_STAGES must be 0 or at least 2");
      end
   endgenerate

   pit_mode_e        mode;
   pit_mode_e        cw_mode;
   logic             cw_wr;
   logic             byte_wr;
   logic [CNT_W-1:0] cnt_val;
   logic             cnt_done;
   logic             gate_lvl;
   logic             gate_rise;
   logic             out_q;

   pit_wr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .mode     (mode),
      .cw_wr    (cw_wr),
      .cw_mode  (cw_mode),
      .byte_wr  (byte_wr),
      .cnt_val  (cnt_val),
      .cnt_done (cnt_done)
   );

   pit_gate_edge #(.SYNC_STAGES(SYNC_STAGES)) u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate_raw  (en_gate),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise)
   );

   pit_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode      (mode),
      .cw_wr     (cw_wr),
      .cw_mode   (cw_mode),
      .byte_wr   (byte_wr),
      .cnt_val   (cnt_val),
      .cnt_done  (cnt_done),
      .gate_lvl  (gate_lvl),
      .gate_rise (gate_rise),
      .out_q     (out_q)
   );

   // in the periodic modes a low gate lifts the output without waiting for a clock
   assign wave_o = out_q | (~gate_lvl & (mode == PM_RATE || mode == PM_SQUARE));

   AST_M0_CW_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel && wr_data[3:1] == 3'b000 |=> !wave_o); // R2

endmodule

// File: tb/tb_pit_counter.sv
module tb_pit_counter;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic       wr_sel = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       en_gate = 1'b1;
   logic       wave_o;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   pit_counter dut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .en_gate (en_gate),
      .wave_o  (wave_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // called at a negedge; the write is taken at the next rising edge
   task automatic wr(input logic sel, input logic [7:0] d);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_level(input logic lvl, input int limit, output int n);
      n = 0;
      while (wave_o !== lvl && n < limit) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic count_lows(input int cycles, output int lows);
      lows = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (wave_o == 1'b0) lows++;
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int n, lows, first;
      @(negedge clk);
      chk("R12 out during reset", wave_o, 1);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R12 out after reset", wave_o, 1);

      // mode 0 sweep
      for (int nv = 1; nv <= 8; nv++) begin
         wr(1'b1, 8'h00);
         chk("R2 mode0 low after control word", wave_o, 0);
         wr(1'b0, 8'(nv));
         wait_level(1'b1, 100, n);
         chk("R2 mode0 rise delay", n, nv + 1);
         count_lows(6, lows);
         chk("R2 mode0 stays high", lows, 0);
      end

      // mode 0 gate pause
      wr(1'b1, 8'h00);
      wr(1'b0, 8'd5);
      first = 0;
      for (int i = 1; i <= 60; i++) begin
         @(negedge clk);
         if (wave_o && first == 0) first = i;
         if (i == 2) en_gate = 1'b0;
         if (i == 5) en_gate = 1'b1;
      end
      chk("R3 mode0 gate low pauses", first, 9);

      // mode 0 two-byte counts
      wr(1'b1, 8'h10);
      wr(1'b0, 8'h03);
      wr(1'b0, 8'h00);
      wait_level(1'b1, 100, n);
      chk("R4 mode0 two-byte count", n, 4);
      wr(1'b0, 8'h02);
      chk("R4 low byte forces low", wave_o, 0);
      count_lows(6, lows);
      chk("R4 halted between bytes", lows, 6);
      wr(1'b0, 8'h01);
      wait_level(1'b1, 400, n);
      chk("R4 rise after high byte", n, 259);

      // mode 1 one-shot sweep
      en_gate = 1'b0;
      wr(1'b1, 8'h02);
      chk("R5 mode1 idle high", wave_o, 1);
      for (int nv = 1; nv <= 6; nv++) begin
         wr(1'b0, 8'(nv));
         count_lows(3, lows);
         chk("R5 mode1 no pulse without trigger", lows, 0);
         en_gate = 1'b1;
         @(negedge clk);
         chk("R5 mode1 low after trigger", wave_o, 0);
         wait_level(1'b1, 50, n);
         chk("R5 mode1 pulse width", n, nv);
         en_gate = 1'b0;
         @(negedge clk);
      end
      // retrigger with a newer count
      wr(1'b0, 8'd6);
      en_gate = 1'b1;
      @(negedge clk);
      en_gate = 1'b0;
      @(negedge clk);
      wr(1'b0, 8'd4);
      chk("R5 mode1 still low before retrigger", wave_o, 0);
      en_gate = 1'b1;
      @(negedge clk);
      wait_level(1'b1, 50, n);
      chk("R5 mode1 retrigger uses newest count", n, 4);

      // mode 2 rate sweep
      en_gate = 1'b1;
      for (int nv = 2; nv <= 7; nv++) begin
         wr(1'b1, 8'h04);
         wr(1'b0, 8'(nv));
         wait_level(1'b0, 50, n);
         chk("R6 mode2 first low", n, nv);
         @(negedge clk);
         chk("R6 mode2 one clock low", wave_o, 1);
         wait_level(1'b0, 50, n);
         chk("R6 mode2 period", n, nv - 1);
      end
      // gate forcing and gate restart, N = 7 still loaded
      en_gate = 1'b0;
      #1;
      chk("R6 mode2 gate low forces high", wave_o, 1);
      count_lows(5, lows);
      chk("R6 mode2 held high while gate low", lows, 0);
      en_gate = 1'b1;
      wait_level(1'b0, 50, n);
      chk("R6 mode2 low after gate rise", n, 7);
      // new count mid-period (R8)
      wr(1'b1, 8'h04);
      wr(1'b0, 8'd5);
      wait_level(1'b0, 50, n);
      @(negedge clk);
      wr(1'b0, 8'd3);
      wait_level(1'b0, 50, n);
      chk("R8 mode2 current period keeps old count", n, 3);
      @(negedge clk);
      wait_level(1'b0, 50, n);
      chk("R8 mode2 next period uses new count", n, 2);

      // control word code 6 behaves as mode 2
      wr(1'b1, 8'h0C);
      wr(1'b0, 8'd3);
      wait_level(1'b0, 50, n);
      chk("R1 code 6 first low", n, 3);
      @(negedge clk);
      wait_level(1'b0, 50, n);
      chk("R1 code 6 period", n, 2);

      // mode 3 square sweep
      for (int nv = 2; nv <= 9; nv++) begin
         wr(1'b1, 8'h06);
         wr(1'b0, 8'(nv));
         wait_level(1'b0, 50, n);
         chk("R7 mode3 first high incl load", n, (nv + 1) / 2 + 1);
         wait_level(1'b1, 50, n);
         chk("R7 mode3 low half", n, nv / 2);
         wait_level(1'b0, 50, n);
         chk("R7 mode3 high half", n, (nv + 1) / 2);
      end
      en_gate = 1'b0;
      #1;
      chk("R7 mode3 gate low forces high", wave_o, 1);
      @(negedge clk);
      en_gate = 1'b1;
      // new count mid-half (R8): 8 running, rewrite to 4
      wr(1'b1, 8'h06);
      wr(1'b0, 8'd8);
      wait_level(1'b0, 50, n);
      @(negedge clk);
      wr(1'b0, 8'd4);
      wait_level(1'b1, 50, n);
      chk("R8 mode3 current half keeps old count", n, 2);
      wait_level(1'b0, 50, n);
      chk("R8 mode3 next half uses new count", n, 2);

      // mode 4 software strobe sweep
      for (int nv = 1; nv <= 6; nv++) begin
         wr(1'b1, 8'h08);
         wr(1'b0, 8'(nv));
         wait_level(1'b0, 50, n);
         chk("R9 mode4 strobe delay", n, nv + 1);
         @(negedge clk);
         chk("R9 mode4 strobe one clock", wave_o, 1);
         count_lows(2 * nv + 5, lows);
         chk("R9 mode4 no repeat", lows, 0);
      end
      wr(1'b1, 8'h08);
      wr(1'b0, 8'd5);
      repeat (2) @(negedge clk);
      wr(1'b0, 8'd4);
      wait_level(1'b0, 50, n);
      chk("R9 mode4 rewrite restarts", n, 5);

      // mode 5 hardware strobe sweep
      en_gate = 1'b0;
      @(negedge clk);
      for (int nv = 1; nv <= 6; nv++) begin
         wr(1'b1, 8'h0A);
         wr(1'b0, 8'(nv));
         count_lows(8, lows);
         chk("R10 mode5 waits for trigger", lows, 0);
         en_gate = 1'b1;
         wait_level(1'b0, 50, n);
         chk("R10 mode5 strobe delay", n, nv + 1);
         @(negedge clk);
         chk("R10 mode5 strobe one clock", wave_o, 1);
         en_gate = 1'b0;
         @(negedge clk);
      end
      en_gate = 1'b1;
      first = 0;
      for (int i = 1; i <= 30; i++) begin
         @(negedge clk);
         if (!wave_o && first == 0) first = i;
         if (i == 2) en_gate = 1'b0;
         if (i == 3) en_gate = 1'b1;
      end
      chk("R10 mode5 retrigger restarts", first, 10);

      // full-range count
      wr(1'b1, 8'h00);
      wr(1'b0, 8'h00);
      wait_level(1'b1, 70000, n);
      chk("R11 zero count is 65536", n, 65537);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule